// File: doc/BRIEF.md
# Rolling Readout Dual Row-Pointer Scanner

This block generates the row timing for an image array that is read one line at a time. It keeps two row pointers that both advance by one row per line period. The leading pointer names the row whose photodiode receives a dummy reset. The trailing pointer names the row selected for readout. The number of line periods between the two pointers is the effective exposure. While a frame is running, the global in-pixel sample control stays asserted for the whole frame, because the storage capacitor only serves as a bandwidth limit in this mode.

A frame begins with a one-cycle `frame_start_i`. At that moment the exposure input is captured and clamped to the physical row count. The readout pointer loads row 0 and the reset pointer loads the exposure value. Each accepted `row_tick_i` then produces a one-cycle reset strobe for the reset pointer's row. It is followed on the next cycle by a one-cycle read strobe for the readout pointer's row, after which both pointers advance and wrap past the last physical row. The frame closes with a `frame_done_o` pulse that coincides with the read strobe of the last physical row.

Top module: `rowscan_dual_ptr`

## Requirements
- R1: While reset is held and after its release, with no frame started, `rst_stb_o`, `rd_stb_o`, `frame_done_o` and `sample_en_o` are all 0.
- R2: `sample_en_o` is 1 from the cycle after an accepted `frame_start_i` until the cycle after `frame_done_o`, and 0 otherwise.
- R3: A `row_tick_i` accepted while a frame waits for a tick raises `rst_stb_o` for exactly one cycle, in the cycle after the tick. `rd_stb_o` follows for exactly one cycle in the next cycle. The two strobes never overlap. A tick seen while a read is pending is ignored.
- R4: Within a frame, the k-th read strobe (k counted from 0) carries `rd_row_o` = k, for k from 0 to NUM_ROWS-1, so every physical row is read, including rows not yet reset in that frame.
- R5: The k-th reset strobe carries `rst_row_o` = (E + k) mod NUM_ROWS, where E is the latched exposure, so the reset pointer wraps from NUM_ROWS-1 to 0.
- R6: With E = 0, reset and read name the same row in the same row period, and the reset strobe comes first.
- R7: An exposure input of NUM_ROWS or more is latched as NUM_ROWS-1.
- R8: The exposure is sampled only on `frame_start_i`. Changes to `exp_rows_i` during a frame do not alter that frame's reset rows.
- R9: `frame_done_o` is a one-cycle pulse that coincides with the read strobe of row NUM_ROWS-1. After it, ticks produce no strobes until the next `frame_start_i`.
- R10: A `frame_start_i` during a frame takes priority over everything else. It cancels a pending read strobe, reloads both pointers with the new exposure, and the frame then restarts from read row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | One-cycle request to begin a frame |
| row_tick_i | input | 1 | One-cycle line-period tick, at least 3 cycles apart |
| exp_rows_i | input | ROW_W | Exposure lead in row periods |
| rst_row_o | output | ROW_W | Row index for the dummy photodiode reset |
| rst_stb_o | output | 1 | One-cycle reset strobe |
| rd_row_o | output | ROW_W | Row index selected for readout |
| rd_stb_o | output | 1 | One-cycle read strobe |
| sample_en_o | output | 1 | Global in-pixel sample control |
| frame_done_o | output | 1 | Pulse with the read of the last physical row |

## Verification
The hardest state to reach from the ports is a restart that lands in the single cycle between a reset strobe and its read strobe. The bench issues a tick, waits exactly one edge until the reset strobe is visible, and then raises `frame_start_i` with a new exposure in that same cycle. It then checks that the pending read vanishes and that a complete frame follows from row 0. The reset pointer's wrap, and the rows that are read before they are reset, are reached by running complete 1032-row frames with leads of 0, 5 and an over-range value.

// File: rtl/rowscan_pkg.sv
package rowscan_pkg;

    // Default physical row count of the array (active rows plus margin rows)
    localparam int unsigned ROWSCAN_ROWS_DEF = 1032;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,  // no frame, sample control low
        PH_WAIT  = 2'd1,  // frame running, waiting for a line tick
        PH_READ  = 2'd2,  // reset strobe issued, read strobe next
        PH_CLOSE = 2'd3   // last row read, drop sample control next
    } scan_phase_e;

endpackage

// File: rtl/rowscan_exp_clamp.sv
module rowscan_exp_clamp #(
    parameter int unsigned NUM_ROWS = 1032,
    localparam int unsigned ROW_W = $clog2(NUM_ROWS)
) (
    input  logic [ROW_W-1:0] exp_raw_i,
    output logic [ROW_W-1:0] exp_lim_o
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

    always_comb begin
        if (exp_raw_i > LAST_ROW) begin
            exp_lim_o = LAST_ROW;
        end else begin
            exp_lim_o = exp_raw_i;
        end
    end
endmodule

// File: rtl/rowscan_wrap_ptr.sv
module rowscan_wrap_ptr #(
    parameter int unsigned NUM_ROWS = 1032,
    localparam int unsigned ROW_W = $clog2(NUM_ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [ROW_W-1:0] load_val_i,
    input  logic             step_i,
    output logic [ROW_W-1:0] ptr_o
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

    logic [ROW_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load_i) begin
            ptr_d = load_val_i;
        end else if (step_i) begin
            ptr_d = (ptr_q == LAST_ROW) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr_o = ptr_q;
endmodule

// File: rtl/rowscan_dual_ptr.sv
module rowscan_dual_ptr
    import rowscan_pkg::*;
#(
    parameter int unsigned NUM_ROWS = ROWSCAN_ROWS_DEF,
    localparam int unsigned ROW_W = $clog2(NUM_ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start_i,
    input  logic             row_tick_i,
    input  logic [ROW_W-1:0] exp_rows_i,
    output logic [ROW_W-1:0] rst_row_o,
    output logic             rst_stb_o,
    output logic [ROW_W-1:0] rd_row_o,
    output logic             rd_stb_o,
    output logic             sample_en_o,
    output logic             frame_done_o
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);
    localparam int unsigned NUM_PTRS = 2;
    localparam int unsigned PTR_RD  = 0;
    localparam int unsigned PTR_RST = 1;

    typedef struct packed {
        scan_phase_e      phase;
        logic             rst_stb;
        logic [ROW_W-1:0] rst_row;
        logic             rd_stb;
        logic [ROW_W-1:0] rd_row;
        logic             done;
    } scan_state_t;

    scan_state_t st_d, st_q;

    logic [ROW_W-1:0] exp_lim;
    logic [ROW_W-1:0] ptr_val [NUM_PTRS];
    logic [ROW_W-1:0] ptr_ld  [NUM_PTRS];
    logic             ptr_step;

    rowscan_exp_clamp #(.NUM_ROWS(NUM_ROWS)) u_clamp (
        .exp_raw_i (exp_rows_i),
        .exp_lim_o (exp_lim)
    );

    // Read pointer loads row 0; reset pointer loads the clamped lead.
    assign ptr_ld[PTR_RD]  = '0;
    assign ptr_ld[PTR_RST] = exp_lim;
    assign ptr_step = (st_q.phase == PH_READ) && !frame_start_i;

    for (genvar g = 0; g < NUM_PTRS; g++) begin : g_ptr
        rowscan_wrap_ptr #(.NUM_ROWS(NUM_ROWS)) u_ptr (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (frame_start_i),
            .load_val_i (ptr_ld[g]),
            .step_i     (ptr_step),
            .ptr_o      (ptr_val[g])
        );
    end

    always_comb begin
        st_d         = st_q;
        st_d.rst_stb = 1'b0;
        st_d.rd_stb  = 1'b0;
        st_d.done    = 1'b0;
        if (frame_start_i) begin
            st_d.phase = PH_WAIT;
        end else begin
            unique case (st_q.phase)
                PH_WAIT: begin
                    if (row_tick_i) begin
                        st_d.rst_stb = 1'b1;
                        st_d.rst_row = ptr_val[PTR_RST];
                        st_d.phase   = PH_READ;
                    end
                end
                PH_READ: begin
                    st_d.rd_stb = 1'b1;
                    st_d.rd_row = ptr_val[PTR_RD];
                    if (ptr_val[PTR_RD] == LAST_ROW) begin
                        st_d.done  = 1'b1;
                        st_d.phase = PH_CLOSE;
                    end else begin
                        st_d.phase = PH_WAIT;
                    end
                end
                PH_CLOSE: st_d.phase = PH_IDLE;
                default:  st_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, rst_stb: 1'b0, rst_row: '0,
                      rd_stb: 1'b0, rd_row: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_row_o    = st_q.rst_row;
    assign rst_stb_o    = st_q.rst_stb;
    assign rd_row_o     = st_q.rd_row;
    assign rd_stb_o     = st_q.rd_stb;
    assign frame_done_o = st_q.done;
    assign sample_en_o  = (st_q.phase != PH_IDLE);
endmodule

// File: rtl/rowscan_dual_ptr_chk.sv
module rowscan_dual_ptr_chk #(
    parameter int unsigned NUM_ROWS = 1032,
    localparam int unsigned ROW_W = $clog2(NUM_ROWS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start_i,
    input logic [ROW_W-1:0] rst_row_o,
    input logic             rst_stb_o,
    input logic [ROW_W-1:0] rd_row_o,
    input logic             rd_stb_o,
    input logic             sample_en_o,
    input logic             frame_done_o
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

    // R3
    rd_follows_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_stb_o && !frame_start_i) |=> rd_stb_o);

    // R3
    no_strobe_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_stb_o && rd_stb_o));

    // R9
    done_on_last_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> (rd_stb_o && rd_row_o == LAST_ROW));

    // R2
    sample_during_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_stb_o || rd_stb_o) |-> sample_en_o);

    // R2
    sample_drops_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done_o && !frame_start_i) |=> !sample_en_o);

    // R5
    rst_row_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_stb_o |-> (rst_row_o <= LAST_ROW));
endmodule

bind rowscan_dual_ptr rowscan_dual_ptr_chk #(.NUM_ROWS(NUM_ROWS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start_i (frame_start_i),
    .rst_row_o     (rst_row_o),
    .rst_stb_o     (rst_stb_o),
    .rd_row_o      (rd_row_o),
    .rd_stb_o      (rd_stb_o),
    .sample_en_o   (sample_en_o),
    .frame_done_o  (frame_done_o)
);

// File: tb/rowscan_dual_ptr_tb.sv
`timescale 1ns/1ps
module rowscan_dual_ptr_tb;
    localparam int N = 1032;
    localparam int W = $clog2(N);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_start_i = 1'b0;
    logic         row_tick_i = 1'b0;
    logic [W-1:0] exp_rows_i = '0;
    logic [W-1:0] rst_row_o, rd_row_o;
    logic         rst_stb_o, rd_stb_o, sample_en_o, frame_done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rowscan_dual_ptr #(.NUM_ROWS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i),
        .row_tick_i(row_tick_i), .exp_rows_i(exp_rows_i),
        .rst_row_o(rst_row_o), .rst_stb_o(rst_stb_o),
        .rd_row_o(rd_row_o), .rd_stb_o(rd_stb_o),
        .sample_en_o(sample_en_o), .frame_done_o(frame_done_o)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic start_frame(int e);
        @(negedge clk);
        frame_start_i = 1'b1;
        exp_rows_i = W'(e);
        @(posedge clk);
        @(negedge clk);
        frame_start_i = 1'b0;
        chk(sample_en_o == 1'b1, "R2 sample after start", sample_en_o, 1);
    endtask

    // One line period: reset strobe, then read strobe, then one idle cycle.
    task automatic tick_row(int exp_rst, int exp_rd, bit last);
        row_tick_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        row_tick_i = 1'b0;
        chk(rst_stb_o == 1'b1, "R3 reset strobe", rst_stb_o, 1);
        chk(rd_stb_o == 1'b0, "R3 read not yet", rd_stb_o, 0);
        chk(int'(rst_row_o) == exp_rst, "R5 reset row", rst_row_o, exp_rst);
        @(posedge clk);
        @(negedge clk);
        chk(rd_stb_o == 1'b1, "R3 read strobe", rd_stb_o, 1);
        chk(rst_stb_o == 1'b0, "R3 reset one cycle", rst_stb_o, 0);
        chk(int'(rd_row_o) == exp_rd, "R4 read row", rd_row_o, exp_rd);
        chk(frame_done_o == last, "R9 done pulse", frame_done_o, int'(last));
        chk(sample_en_o == 1'b1, "R2 sample held", sample_en_o, 1);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_frame(int e_eff, int k0, int chg_at, int chg_val);
        for (int k = k0; k < N; k++) begin
            if (k == chg_at) exp_rows_i = W'(chg_val);
            tick_row((e_eff + k) % N, k, k == N - 1);
        end
        chk(sample_en_o == 1'b0, "R2 sample low after done", sample_en_o, 0);
        chk(frame_done_o == 1'b0, "R9 done one cycle", frame_done_o, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!rst_stb_o && !rd_stb_o, "R1 strobes in reset", rst_stb_o | rd_stb_o, 0);
        chk(sample_en_o == 1'b0, "R1 sample in reset", sample_en_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        row_tick_i = 1'b1;
        @(negedge clk);
        row_tick_i = 1'b0;
        @(negedge clk);
        chk(!rst_stb_o && !rd_stb_o && !frame_done_o, "R1 idle tick", rst_stb_o, 0);
        chk(sample_en_o == 1'b0, "R1 sample idle", sample_en_o, 0);
    endtask

    task automatic t_basic();
        start_frame(5);
        run_frame(5, 0, -1, 0);
    endtask

    task automatic t_zero();
        start_frame(0);
        run_frame(0, 0, -1, 0); // R6 same row, reset first
    endtask

    task automatic t_clamp();
        start_frame(2000);
        run_frame(N - 1, 0, -1, 0); // R7 over-range lead clamps
    endtask

    task automatic t_latch();
        start_frame(10);
        run_frame(10, 0, 3, 100); // R8 mid-frame change ignored
    endtask

    task automatic t_idle_after_done();
        @(negedge clk);
        row_tick_i = 1'b1;
        @(negedge clk);
        row_tick_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(!rst_stb_o && !rd_stb_o, "R9 no strobe after done", rst_stb_o | rd_stb_o, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_restart();
        start_frame(7);
        for (int k = 0; k < 5; k++) tick_row((7 + k) % N, k, 1'b0);
        row_tick_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        row_tick_i = 1'b0;
        chk(rst_stb_o == 1'b1, "R10 reset before restart", rst_stb_o, 1);
        frame_start_i = 1'b1;
        exp_rows_i = W'(3);
        @(posedge clk);
        @(negedge clk);
        frame_start_i = 1'b0;
        chk(rd_stb_o == 1'b0, "R10 pending read cancelled", rd_stb_o, 0);
        chk(sample_en_o == 1'b1, "R10 sample held", sample_en_o, 1);
        @(negedge clk);
        run_frame(3, 0, -1, 0); // R10 restart from row 0 with new lead
    endtask

    initial begin
        t_reset();
        t_basic();
        t_idle_after_done();
        t_zero();
        t_clamp();
        t_latch();
        t_restart();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule